// File: doc/BRIEF.md
# Register-Mapped 16-Bit Reload Timer

A 16-bit down-counting timer that software drives through four word registers on a simple synchronous bus: a reload value, a read-only live count, a control word and a write-only acknowledge location. The control word turns the timer on, picks a reload policy, chooses one of three count sources and sets a prescale ratio. When the count runs out, the timer raises a level interrupt that stays asserted until software acknowledges it.

The count sources are one-cycle enable strobes in the system clock domain: a main-rate strobe, a secondary strobe and a slow-oscillator strobe. The prescaler counts only strobes from the selected source, and it produces one count step per 1, 16 or 256 of them. The counter handles expiry in one of two ways. In periodic mode it reloads from the reload register. In free-running mode it wraps to 0xFFFF. The interrupt is raised in both modes.

Top module: `reload_timer16`

## Requirements
- R1: After reset the reload register reads 0x0000, the live count reads 0xFFFF, the control word reads 0x0000 and `irq` is low.
- R2: Register word index is `bus_addr[3:2]`: 0 reload (read/write), 1 live count (read-only), 2 control (read/write), 3 acknowledge (write-only, reads 0). Control fields are bit 7 run, bit 6 periodic, bits 5:4 source, bits 3:2 prescale. Bits 15:8 and 1:0 always read as zero.
- R3: Writes to the live-count location leave the count unchanged.
- R4: A control write with bit 7 set while the timer is stopped loads the count from the reload register and restarts the prescaler phase. The same write while already running does neither.
- R5: While bit 7 is clear, the count holds regardless of source strobes.
- R6: Prescale code 00 steps on every selected strobe, 01 on every 16th, 10 on every 256th, and 11 behaves as 00.
- R7: Source code 00 counts `src_main_en`, 01 counts `src_alt_en` and 10 counts `src_osc_en`. Strobes of unselected sources are ignored, and code 11 leaves the count frozen.
- R8: In periodic mode, a step taken at count 0 reloads the count from the reload register and sets `irq`.
- R9: In free-running mode, a step taken at count 0 wraps the count to 0xFFFF and sets `irq`.
- R10: `irq` stays high until any write to the acknowledge location. An expiry and an acknowledge in the same cycle leave `irq` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write when high, with `bus_sel` |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| src_main_en | input | 1 | Main-clock count strobe |
| src_alt_en | input | 1 | Secondary-clock count strobe |
| src_osc_en | input | 1 | Slow-oscillator count strobe |
| irq | output | 1 | Expiry interrupt, level |

## Verification
The counter is driven with strobes on the selected source interleaved with strobes on the other two sources. This shows whether source selection actually gates counting. Expiry is run in both modes, so a reload to the programmed value can be told apart from a wrap to 0xFFFF. Both long prescale ratios are counted one strobe short of the boundary and then one strobe onto it, which exposes off-by-one dividers and a code 11 that fails to act as divide-by-1. Re-enabling partway through a prescale period shows whether the phase restarts. An expiry is placed in the same cycle as an acknowledge to fix the priority between them.

// File: rtl/reload_timer16.sv
module reload_timer16 #(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              src_main_en,
  input  logic              src_alt_en,
  input  logic              src_osc_en,
  output logic              irq
);
  localparam logic [PRE_W-1:0] LAST16  = PRE_W'(15);
  localparam logic [PRE_W-1:0] LAST256 = PRE_W'(255);

  logic [DATA_W-1:0] load_q, cnt_q;
  logic [PRE_W-1:0]  pre_cnt;
  logic              en_q, per_q, irq_q;
  logic [1:0]        src_q, pre_q;
  logic              src_pulse;
  logic [PRE_W-1:0]  pre_last;

  wire [1:0] idx     = bus_addr[3:2];
  wire       wr_any  = bus_sel & bus_wr;
  wire       wr_load = wr_any & (idx == 2'd0);
  wire       wr_ctrl = wr_any & (idx == 2'd2);
  wire       wr_clr  = wr_any & (idx == 2'd3);
  wire       en_rise = wr_ctrl & bus_wdata[7] & ~en_q;

  always_comb begin
    case (src_q)
      2'd0:    src_pulse = src_main_en;
      2'd1:    src_pulse = src_alt_en;
      2'd2:    src_pulse = src_osc_en;
      default: src_pulse = 1'b0;
    endcase
    case (pre_q)
      2'd1:    pre_last = LAST16;
      2'd2:    pre_last = LAST256;
      default: pre_last = '0;
    endcase
  end

  wire src_step = en_q & src_pulse;
  wire tick     = src_step & (pre_cnt >= pre_last);
  wire expire   = tick & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      src_q  <= 2'd0;
      pre_q  <= 2'd0;
    end else begin
      if (wr_load) load_q <= bus_wdata;
      if (wr_ctrl) begin
        en_q  <= bus_wdata[7];
        per_q <= bus_wdata[6];
        src_q <= bus_wdata[5:4];
        pre_q <= bus_wdata[3:2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt_q   <= '1;
    end else if (en_rise) begin
      pre_cnt <= '0;
      cnt_q   <= load_q;
    end else if (src_step) begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) cnt_q <= expire ? (per_q ? load_q : '1) : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (expire) irq_q <= 1'b1;
    else if (wr_clr) irq_q <= 1'b0;
  end

  assign irq = irq_q;

  always_comb begin
    case (idx)
      2'd0:    bus_rdata = load_q;
      2'd1:    bus_rdata = cnt_q;
      2'd2:    bus_rdata = DATA_W'({en_q, per_q, src_q, pre_q, 2'b00});
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/reload_timer16_chk.sv
module reload_timer16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        irq,
  input logic        en_q,
  input logic        per_q,
  input logic        tick,
  input logic [15:0] cnt_q,
  input logic [15:0] load_q
);
  wire w_ctrl = bus_sel & bus_wr & (bus_addr[3:2] == 2'd2);
  wire w_clr  = bus_sel & bus_wr & (bus_addr[3:2] == 2'd3);

  AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && bus_wdata[7] && !en_q) |=> (cnt_q == $past(load_q))); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !w_ctrl) |=> $stable(cnt_q)); // R5
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && per_q && tick && cnt_q == 16'd0 && !w_ctrl) |=> (cnt_q == $past(load_q))); // R8
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !per_q && tick && cnt_q == 16'd0 && !w_ctrl) |=> (cnt_q == 16'hFFFF)); // R9
  AST_IRQ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cnt_q) == 16'd0)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !w_clr) |=> irq); // R10
endmodule

bind reload_timer16 reload_timer16_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
  .en_q(en_q), .per_q(per_q), .tick(tick), .cnt_q(cnt_q), .load_q(load_q)
);

// File: tb/test_reload_timer16.sv
`timescale 1ns/1ps
module test_reload_timer16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        src_main_en = 1'b0, src_alt_en = 1'b0, src_osc_en = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;

  reload_timer16 i_reload_timer16 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_main_en(src_main_en), .src_alt_en(src_alt_en), .src_osc_en(src_osc_en),
    .irq(irq)
  );

  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      item_t it;
      logic [15:0] act;
      it  = exp_q.pop_front();
      act = it.is_irq ? {15'd0, irq} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    step();
  endtask

  task automatic chk_irq(input bit e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {15'd0, e}; it.tag = tag;
    exp_q.push_back(it);
    step();
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      src_main_en = (which == 0);
      src_alt_en  = (which == 1);
      src_osc_en  = (which == 2);
      step();
    end
    src_main_en = 1'b0; src_alt_en = 1'b0; src_osc_en = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1
    chk_rd(4'h0, 16'h0000, "R1 reload reset");
    chk_rd(4'h4, 16'hFFFF, "R1 count reset");
    chk_rd(4'h8, 16'h0000, "R1 control reset");
    chk_irq(1'b0, "R1 irq reset");
    // R2, R4, R7: reserved bits, start reload, source 11 frozen
    wr(4'h0, 16'h1234);
    chk_rd(4'h0, 16'h1234, "R2 reload readback");
    wr(4'h8, 16'hFFFF);
    chk_rd(4'h8, 16'h00FC, "R2 control reserved zero");
    chk_rd(4'hC, 16'h0000, "R2 ack reads zero");
    chk_rd(4'h4, 16'h1234, "R4 start loads count");
    pulse(0, 5); pulse(1, 5); pulse(2, 5);
    chk_rd(4'h4, 16'h1234, "R7 source 11 frozen");
    // R3
    wr(4'h4, 16'h0000);
    chk_rd(4'h4, 16'h1234, "R3 count read-only");
    // R9, R7, R10: free-running on main source
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0005);
    wr(4'h8, 16'h0080);
    pulse(0, 3);
    chk_rd(4'h4, 16'h0002, "R6 divide-by-1 steps");
    pulse(1, 4); pulse(2, 4);
    chk_rd(4'h4, 16'h0002, "R7 other sources ignored");
    pulse(0, 2);
    chk_rd(4'h4, 16'h0000, "R9 reached zero");
    chk_irq(1'b0, "R9 no irq before expiry");
    pulse(0, 1);
    chk_rd(4'h4, 16'hFFFF, "R9 wrap to FFFF");
    chk_irq(1'b1, "R9 irq on wrap");
    pulse(0, 3);
    wr(4'h4, 16'h0000);
    chk_irq(1'b1, "R10 irq sticky");
    chk_rd(4'h4, 16'hFFFC, "R9 continues after wrap");
    wr(4'hC, 16'hABCD);
    chk_irq(1'b0, "R10 ack clears irq");
    // R5
    wr(4'h8, 16'h0000);
    pulse(0, 4);
    chk_rd(4'h4, 16'hFFFC, "R5 hold when stopped");
    // R8: periodic on secondary source
    wr(4'h0, 16'h0002);
    wr(4'h8, 16'h00D0);
    pulse(1, 2);
    chk_rd(4'h4, 16'h0000, "R8 reached zero");
    pulse(1, 1);
    chk_rd(4'h4, 16'h0002, "R8 reload on expiry");
    chk_irq(1'b1, "R8 irq on reload");
    wr(4'hC, 16'h0000);
    pulse(1, 3);
    chk_rd(4'h4, 16'h0002, "R8 second period");
    chk_irq(1'b1, "R8 irq second period");
    wr(4'hC, 16'h0000);
    // R4: rewrite while running
    pulse(1, 1);
    wr(4'h8, 16'h00D0);
    chk_rd(4'h4, 16'h0001, "R4 no reload while running");
    // R6, R4: divide-by-16 on oscillator, phase restart
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0003);
    wr(4'h8, 16'h00E4);
    pulse(2, 15);
    chk_rd(4'h4, 16'h0003, "R6 div16 15 strobes");
    pulse(2, 1);
    chk_rd(4'h4, 16'h0002, "R6 div16 16th strobe");
    pulse(2, 8);
    wr(4'h8, 16'h0000);
    wr(4'h8, 16'h00E4);
    pulse(2, 15);
    chk_rd(4'h4, 16'h0003, "R4 phase restarted");
    pulse(2, 1);
    chk_rd(4'h4, 16'h0002, "R4 phase restart step");
    // R6: divide-by-256
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0001);
    wr(4'h8, 16'h0088);
    pulse(0, 255);
    chk_rd(4'h4, 16'h0001, "R6 div256 255 strobes");
    pulse(0, 1);
    chk_rd(4'h4, 16'h0000, "R6 div256 256th strobe");
    // R6: code 11 as divide-by-1
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0004);
    wr(4'h8, 16'h008C);
    pulse(0, 1);
    chk_rd(4'h4, 16'h0003, "R6 code 11 divide-by-1");
    // R10: expiry and ack in the same cycle
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0001);
    wr(4'h8, 16'h0080);
    pulse(0, 1);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 16'h0;
    src_main_en = 1'b1;
    step();
    bus_sel = 1'b0; bus_wr = 1'b0; src_main_en = 1'b0;
    chk_irq(1'b1, "R10 expiry beats ack");
    chk_rd(4'h4, 16'hFFFF, "R9 wrap with ack");
    wr(4'hC, 16'h0001);
    chk_irq(1'b0, "R10 later ack clears");
    step(); step();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule